// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 32-bit watchdog that counts down once software has enabled its interrupt. The first time the count reaches zero it raises a timeout interrupt and reloads. If that interrupt is still pending at the next zero and resets are enabled, it issues a one-cycle reset request. Software reaches it through a simple register bus with a select, a write strobe, an address, write data and combinational read data.

A key-based lock protects the configuration. Writing the key value opens the registers, and writing any other value to the lock register closes them again. While the block is locked, only the test-enable bit can still be changed. A test mode turns a would-be reset into a recorded cause bit plus an interrupt. A stall option freezes the count while a debugger holds the CPU halted.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset:
  - The load and value registers read 0xFFFFFFFF.
  - The control, raw status, masked status, test, cause and lock registers read 0.
  - The outputs irq_o, irq_nmi_o and rst_req_o are low.
- R2: A permitted write to the load register (offset 0x000) stores the value and places it in the counter at that clock edge. The value register (offset 0x004) returns the live count. The count falls by one per clock while the interrupt enable is set, and holds while it is clear.
- R3: On an active cycle with a count of zero, the raw interrupt (status offset 0x010, bit 0) is set and the count reloads from the load register. After loading L, raw goes high exactly L+1 clocks after the load write.
- R4: Writing 0x00000000 to the load register sets the raw interrupt at that same edge, whether or not the interrupt enable is set.
- R5: A permitted write of any value to the clear register (offset 0x00C) clears the raw interrupt, clears cause bit 1 and reloads the count from the load register. The clear register reads as 0.
- R6: The control register (offset 0x008) has three fields:
  - bit 0 is the interrupt enable;
  - bit 1 is the reset enable;
  - bit 2 is the interrupt type, where 1 means non-maskable.
  Writing 0 to bit 0 does not clear an interrupt enable that is already set.
- R7: The masked status (offset 0x014, bit 0) equals raw AND the interrupt enable. irq_o follows the masked status, and irq_nmi_o is irq_o AND the type bit.
- R8: When the count reaches zero while raw is already set and the reset enable is set, rst_req_o is high for exactly one clock, in the cycle after that edge.
- R9: The test register (offset 0x418) has two bits:
  - With bit 0 (test enable) set, rst_req_o stays low. In its place, cause bit 1 (offset 0x41C) is set and the interrupt stays raised.
  - Cause bit 0 mirrors raw.
- R10: The lock register (offset 0xC00) starts unlocked. Writing 0x1ACCE551 unlocks and any other value locks. A read returns 0 when unlocked and 1 when locked.
- R11: While locked, writes to the load, control and clear registers and to the stall bit are ignored. The test-enable bit stays writable.
- R12: With test register bit 8 (stall) set and dbg_halt high, the count holds, and it resumes when dbg_halt falls. With stall clear, dbg_halt has no effect.
- R13: Reserved bits and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while selected |
| dbg_halt | input | 1 | CPU halted by debugger |
| irq_o | output | 1 | Timeout interrupt |
| irq_nmi_o | output | 1 | Interrupt is of the non-maskable type |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The countdown is swept over load values 1 to 5, checking the value register every clock up to the first timeout. This separates an off-by-one in the reload from one in the detection of zero. A two-timeout run with the reset enable set tells a one-cycle reset pulse apart from a level. Repeating that run with test mode set shows that the reset is redirected into the cause bit instead. Zero loads with the interrupt enable clear and then set, together with the type bit, separate raw from masked status and the non-maskable flag. Locked writes to each register, halts with the stall bit set and clear, and a write of 0 to the enable bit each check that state which should hold did not move.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_VALUE = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_CLEAR = 12'h00C;
  localparam logic [11:0] OFS_RAW   = 12'h010;
  localparam logic [11:0] OFS_MASK  = 12'h014;
  localparam logic [11:0] OFS_TEST  = 12'h418;
  localparam logic [11:0] OFS_CAUSE = 12'h41C;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;

  localparam int unsigned STALL_BIT = 8;

  typedef struct packed {
    logic nmi_type;
    logic rst_en;
    logic irq_en;
  } wd_ctrl_t;

  // Interrupt enable can only be set by software; reset clears it.
  function automatic logic sticky_or(input logic cur, input logic req);
    return cur | req;
  endfunction

endpackage

// File: rtl/wd_regfile.sv
module wd_regfile
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              raw_i,
  input  logic              cause_rst_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] load_q,
  output wd_ctrl_t          ctrl_q,
  output logic              stall_q,
  output logic              test_en_q,
  output logic              load_wr,
  output logic              clr_wr,
  output logic              load_zero
);

  localparam int unsigned PAD_CTRL  = DATA_W - 3;
  localparam int unsigned PAD_ONE   = DATA_W - 1;
  localparam int unsigned PAD_CAUSE = DATA_W - 2;
  localparam int unsigned PAD_TEST  = DATA_W - STALL_BIT - 1;

  logic locked_q;
  logic wr_go;
  logic open_wr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_go     = bus_sel && bus_wr;
  assign open_wr   = wr_go && !locked_q;
  assign load_wr   = open_wr && hit(bus_addr, OFS_LOAD);
  assign clr_wr    = open_wr && hit(bus_addr, OFS_CLEAR);
  assign load_zero = load_wr && (bus_wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      load_q    <= '1;
      ctrl_q    <= '0;
      stall_q   <= 1'b0;
      test_en_q <= 1'b0;
    end else begin
      if (wr_go && hit(bus_addr, OFS_LOCK))
        locked_q <= (bus_wdata != UNLOCK_KEY);
      if (load_wr)
        load_q <= bus_wdata;
      if (open_wr && hit(bus_addr, OFS_CTRL)) begin
        ctrl_q.irq_en   <= sticky_or(ctrl_q.irq_en, bus_wdata[0]);
        ctrl_q.rst_en   <= bus_wdata[1];
        ctrl_q.nmi_type <= bus_wdata[2];
      end
      if (wr_go && hit(bus_addr, OFS_TEST)) begin
        test_en_q <= bus_wdata[0];
        if (!locked_q)
          stall_q <= bus_wdata[STALL_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit(bus_addr, OFS_LOAD))       bus_rdata = load_q;
      else if (hit(bus_addr, OFS_VALUE)) bus_rdata = count_i;
      else if (hit(bus_addr, OFS_CTRL))  bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
      else if (hit(bus_addr, OFS_RAW))   bus_rdata = {{PAD_ONE{1'b0}}, raw_i};
      else if (hit(bus_addr, OFS_MASK))  bus_rdata = {{PAD_ONE{1'b0}}, raw_i & ctrl_q.irq_en};
      else if (hit(bus_addr, OFS_TEST))  bus_rdata = {{PAD_TEST{1'b0}}, stall_q, 7'b0, test_en_q};
      else if (hit(bus_addr, OFS_CAUSE)) bus_rdata = {{PAD_CAUSE{1'b0}}, cause_rst_i, raw_i};
      else if (hit(bus_addr, OFS_LOCK))  bus_rdata = {{PAD_ONE{1'b0}}, locked_q};
      else                               bus_rdata = '0;
    end
  end

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              stall_en,
  input  logic              dbg_halt,
  input  logic              load_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count_o,
  output logic              run_o,
  output logic              expire_o
);

  function automatic logic [DATA_W-1:0] dec(input logic [DATA_W-1:0] v);
    return v - DATA_W'(1);
  endfunction

  assign run_o    = irq_en && !(stall_en && dbg_halt);
  assign expire_o = run_o && (count_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        count_o <= '1;
    else if (load_wr)  count_o <= wdata;
    else if (clr_wr)   count_o <= load_q;
    else if (expire_o) count_o <= load_q;
    else if (run_o)    count_o <= dec(count_o);
  end

endmodule

// File: rtl/wd_escalate.sv
module wd_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic load_zero,
  input  logic clr_wr,
  input  logic rst_en,
  input  logic test_en,
  output logic raw_q,
  output logic cause_rst_q,
  output logic rst_req_q,
  output logic reset_ev
);

  assign reset_ev = expire && raw_q && rst_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q       <= 1'b0;
      cause_rst_q <= 1'b0;
      rst_req_q   <= 1'b0;
    end else begin
      if (clr_wr)                    raw_q <= 1'b0;
      else if (expire || load_zero)  raw_q <= 1'b1;
      if (clr_wr)                    cause_rst_q <= 1'b0;
      else if (reset_ev && test_en)  cause_rst_q <= 1'b1;
      rst_req_q <= reset_ev && !test_en;
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq_o,
  output logic              irq_nmi_o,
  output logic              rst_req_o
);

  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] count;
  wd_ctrl_t          ctrl_q;
  logic              stall_q;
  logic              test_en_q;
  logic              load_wr;
  logic              clr_wr;
  logic              load_zero;
  logic              run;
  logic              expire;
  logic              raw;
  logic              cause_rst;
  logic              reset_ev;

  wd_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count_i(count),
    .raw_i(raw), .cause_rst_i(cause_rst), .bus_rdata(bus_rdata),
    .load_q(load_q), .ctrl_q(ctrl_q), .stall_q(stall_q),
    .test_en_q(test_en_q), .load_wr(load_wr), .clr_wr(clr_wr),
    .load_zero(load_zero)
  );

  wd_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .irq_en(ctrl_q.irq_en), .stall_en(stall_q),
    .dbg_halt(dbg_halt), .load_wr(load_wr), .clr_wr(clr_wr),
    .wdata(bus_wdata), .load_q(load_q), .count_o(count), .run_o(run),
    .expire_o(expire)
  );

  wd_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .expire(expire), .load_zero(load_zero),
    .clr_wr(clr_wr), .rst_en(ctrl_q.rst_en), .test_en(test_en_q),
    .raw_q(raw), .cause_rst_q(cause_rst), .rst_req_q(rst_req_o),
    .reset_ev(reset_ev)
  );

  assign irq_o     = raw & ctrl_q.irq_en;
  assign irq_nmi_o = irq_o & ctrl_q.nmi_type;

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              irq_nmi_o,
  input logic              rst_req_o,
  input logic              dbg_halt,
  input logic              inten,
  input logic              stall,
  input logic              test_en,
  input logic [DATA_W-1:0] count,
  input logic              raw,
  input logic              load_wr,
  input logic              clr_wr
);

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_test_blocks_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_en) |-> !rst_req_o);

  assert_inten_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inten) |-> inten);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && dbg_halt && !(bus_sel && bus_wr)) |=> $stable(count));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inten && !load_wr && !clr_wr) |=> $stable(count));

  assert_zero_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && bus_wdata == '0) |=> raw);

  assert_nmi_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi_o |-> irq_o);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .irq_nmi_o(irq_nmi_o),
  .rst_req_o(rst_req_o), .dbg_halt(dbg_halt), .inten(ctrl_q.irq_en),
  .stall(stall_q), .test_en(test_en_q), .count(count), .raw(raw),
  .load_wr(load_wr), .clr_wr(clr_wr)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/100ps
module sim_keyed_watchdog;

  localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_TEST = 12'h418, A_CAUSE = 12'h41C, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, dbg_halt = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, irq_nmi_o, rst_req_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .irq_o(irq_o), .irq_nmi_o(irq_nmi_o),
    .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 / R13: reset state and reserved space
    rchk("R1 load", A_LOAD, 32'hFFFF_FFFF);
    rchk("R1 value", A_VAL, 32'hFFFF_FFFF);
    rchk("R1 ctrl", A_CTRL, 0);
    rchk("R1 raw", A_RAW, 0);
    rchk("R1 mask", A_MASK, 0);
    rchk("R1 test", A_TEST, 0);
    rchk("R1 cause", A_CAUSE, 0);
    rchk("R1 lock", A_LOCK, 0);
    rchk("R13 unmapped", 12'h100, 0);
    chk("R1 outputs", {29'd0, irq_o, irq_nmi_o, rst_req_o}, 0);

    // R4 / R7: zero load with interrupt enable clear
    wr(A_LOAD, 0);
    rchk("R4 raw on zero load", A_RAW, 1);
    rchk("R7 masked while disabled", A_MASK, 0);
    chk("R7 irq while disabled", irq_o, 0);
    wr(A_CLR, 32'hDEAD);
    rchk("R5 clear raw", A_RAW, 0);
    rchk("R13 clear reads zero", A_CLR, 0);

    // R2: counter holds while disabled
    wr(A_LOAD, 3);
    rchk("R2 load immediate", A_VAL, 3);
    step(3);
    rchk("R2 hold while disabled", A_VAL, 3);

    // R3 / R5 / R7: sweep of load values
    wr(A_CTRL, 1);
    for (int L = 1; L <= 5; L++) begin
      wr(A_LOAD, L);
      for (int k = 1; k <= L + 1; k++) begin
        step(1);
        rchk("R3 countdown value", A_VAL, (k <= L) ? L - k : L);
        rchk("R3 raw timing", A_RAW, (k == L + 1) ? 1 : 0);
      end
      chk("R7 irq after timeout", irq_o, 1);
      rchk("R7 masked after timeout", A_MASK, 1);
      chk("R7 nmi flag low", irq_nmi_o, 0);
      wr(A_CLR, 0);
      rchk("R5 clear drops raw", A_RAW, 0);
      rchk("R5 clear reloads", A_VAL, L);
    end

    // R6: sticky enable and fields
    wr(A_CTRL, 0);
    rchk("R6 enable sticky", A_CTRL, 1);
    wr(A_CTRL, 5);
    rchk("R6 type field", A_CTRL, 5);
    wr(A_LOAD, 0);
    rchk("R4 raw on zero load enabled", A_RAW, 1);
    chk("R7 irq nmi", {30'd0, irq_o, irq_nmi_o}, 3);
    wr(A_LOAD, 20);
    wr(A_CTRL, 3);
    chk("R7 irq standard type", {30'd0, irq_o, irq_nmi_o}, 2);

    // R8: reset request at second timeout
    wr(A_LOAD, 4);
    wr(A_CLR, 0);
    for (int k = 1; k <= 11; k++) begin
      step(1);
      chk("R8 reset pulse", rst_req_o, (k == 10) ? 1 : 0);
      rchk("R8 raw pending", A_RAW, (k >= 5) ? 1 : 0);
    end

    // R9: test mode redirects reset into cause
    wr(A_TEST, 1);
    wr(A_CLR, 0);
    for (int k = 1; k <= 11; k++) begin
      step(1);
      chk("R9 reset suppressed", rst_req_o, 0);
      rchk("R9 cause", A_CAUSE, (k >= 10) ? 3 : ((k >= 5) ? 1 : 0));
    end
    chk("R9 interrupt raised", irq_o, 1);
    wr(A_CLR, 0);
    rchk("R9 cause cleared", A_CAUSE, 0);
    wr(A_CTRL, 1);
    wr(A_TEST, 0);

    // R12: stall
    wr(A_TEST, 32'h100);
    rchk("R13 stall bit position", A_TEST, 32'h100);
    wr(A_LOAD, 50);
    dbg_halt = 1'b1;
    step(3);
    rchk("R12 held while halted", A_VAL, 50);
    dbg_halt = 1'b0;
    step(2);
    rchk("R12 resumes", A_VAL, 48);
    wr(A_TEST, 0);
    dbg_halt = 1'b1;
    rd(A_VAL, v);
    step(2);
    rchk("R12 halt ignored without stall", A_VAL, v - 2);
    dbg_halt = 1'b0;

    // R10 / R11: lock
    wr(A_LOCK, 32'h1234);
    rchk("R10 locked", A_LOCK, 1);
    wr(A_LOAD, 7);
    rchk("R11 load ignored", A_LOAD, 50);
    wr(A_CTRL, 6);
    rchk("R11 ctrl ignored", A_CTRL, 1);
    wr(A_TEST, 32'h101);
    rchk("R11 test enable writable, stall not", A_TEST, 1);
    rd(A_VAL, v);
    wr(A_CLR, 0);
    rchk("R11 clear ignored", A_VAL, v - 1);
    wr(A_LOCK, KEY);
    rchk("R10 unlocked", A_LOCK, 0);
    wr(A_LOAD, 9);
    rchk("R10 load after unlock", A_LOAD, 9);
    rchk("R2 value after unlock", A_VAL, 9);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule